// File: doc/BRIEF.md
# Logarithmic Attenuation Code Decoder

This block sits between a byte-wide processor write port and an external R-2R multiplying converter. The host writes an 8-bit attenuation code. The block latches it and turns it into a 17-bit linear gain word. Each code step lowers the gain by a fixed 0.375 dB, so the word follows a decaying exponential of the code. Code zero gives full scale. The sixteen codes whose upper nibble is all ones give a muted, all-zero word.

The gain word is built from two small coefficient tables that are computed at elaboration. The low nibble picks a fine factor covering 0 to 5.625 dB. The high nibble picks a coarse factor in 6 dB steps. The two factors are multiplied, rounded and registered.

Chip select and write strobe reach the block asynchronously, so they are brought onto the system clock by flop synchronizers. A build-time parameter selects one of two loading styles. In edge mode a code loads on the rising edge of the strobe, and a busy flag then holds off further writes for a set number of refresh cycles. In level mode the latch is transparent while both control lines are low.

Top module: `logatt_decoder`

## Requirements
- R1: After reset, and whenever the latched code is 0, the gain word is 17'h1FFFF (full scale). After reset, busy is 0.
- R2: For a latched code N from 0 to 239, the gain word is within ±1 of round(131071 · 10^(-0.375·N/20)). The upper nibble of N therefore adds 6 dB per step, and the lower nibble adds 0.375 dB per step.
- R3: For a latched code from 240 to 255 (upper nibble 4'b1111), the gain word is 0.
- R4: The gain word never increases when the code increases. This holds across the whole code range, including every boundary between upper-nibble rows.
- R5: In edge mode, a rising edge on wr_n while cs_n is low loads the byte that was present on bus_data while wr_n was low. The new gain word appears on the fourth clock edge after the strobe rises at the pins.
- R6: In edge mode, a strobe edge while cs_n is high has no effect. Changes on bus_data while wr_n is held low, with no rising edge, also have no effect.
- R7: In edge mode, busy goes high after each accepted load and stays high for exactly REFRESH_CYCLES clock cycles. Any write whose rising edge falls while busy is high is ignored.
- R8: In level mode, while cs_n and wr_n are both low, the gain word follows bus_data within four clock cycles. Once wr_n is high the last code is held, even if bus_data changes on the same cycle as the strobe rises. In level mode busy stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 8 | Attenuation code from the host bus |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| gain_word | output | 17 | Linear gain word for the R-2R ladder |
| busy | output | 1 | Refresh holdoff after an edge-mode load |

## Verification
The sweep loads all 256 codes in ascending order through the edge-mode port and compares each gain word against the exponential computed in floating point. A table with a wrong coarse entry, or a product rounded or shifted by the wrong amount, would drift far outside ±1 LSB. Scanning the codes in order also catches a non-monotonic step at a row boundary, and a mute region that starts or ends at the wrong code. Dedicated sequences target the control timing:
- Data that changes on the same cycle as the strobe rises checks that the edge path captures the pre-edge byte and that the level path keeps the byte it already held; a design with the wrong capture stage would latch the new byte.
- A strobe edge with chip select high, and a data change while the strobe is held low, each check that no load happens without a proper edge; a design that loaded on these would change its output.
- A second write issued during the holdoff checks that busy blocks it; a design that ignored busy would latch the second code.
- The busy pulse is counted cycle by cycle; a design with an off-by-one refresh counter would report the wrong length.

// File: rtl/logatt_pkg.sv
package logatt_pkg;

    localparam int CODE_W     = 8;
    localparam int NIB_W      = 4;
    localparam int GAIN_W     = 17;
    localparam int FINE_N     = 1 << NIB_W;
    localparam int COARSE_N   = FINE_N - 1;
    localparam int CALC_FRAC  = 40;
    localparam int COEF_FRAC  = 32;
    localparam int COEF_W     = COEF_FRAC + 1;
    localparam int CALC_W     = 96;

    localparam logic [GAIN_W-1:0] GAIN_FULL = '1;

    // 10^(-0.375/20) and 10^(-6/20) scaled by 2^40
    localparam logic [CALC_W-1:0] STEP_FINE_Q40   = 96'd1053052022395;
    localparam logic [CALC_W-1:0] STEP_COARSE_Q40 = 96'd551061191066;

    typedef enum logic {
        LOAD_EDGE  = 1'b0,
        LOAD_LEVEL = 1'b1
    } load_mode_e;

    typedef struct packed {
        logic              cs_n;
        logic              wr_n;
        logic [CODE_W-1:0] data;
    } bus_sample_t;

    typedef struct packed {
        logic [NIB_W-1:0] row;
        logic [NIB_W-1:0] col;
    } code_t;

    localparam bus_sample_t BUS_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, data: '0};

    // step^n in Q40, evaluated with fixed-point arithmetic at elaboration
    function automatic logic [CALC_W-1:0] pow_q40(input logic [CALC_W-1:0] step,
                                                  input int n);
        logic [CALC_W-1:0] q;
        q = 96'd1 << CALC_FRAC;
        for (int i = 0; i < FINE_N; i++) begin
            if (i < n) begin
                q = (q * step + (96'd1 << (CALC_FRAC - 1))) >> CALC_FRAC;
            end
        end
        return q;
    endfunction

    function automatic logic [GAIN_W-1:0] fine_entry(input int n);
        logic [CALC_W-1:0] v;
        v = (pow_q40(STEP_FINE_Q40, n) * CALC_W'(GAIN_FULL)
             + (96'd1 << (CALC_FRAC - 1))) >> CALC_FRAC;
        return v[GAIN_W-1:0];
    endfunction

    function automatic logic [COEF_W-1:0] coarse_entry(input int n);
        logic [CALC_W-1:0] v;
        v = (pow_q40(STEP_COARSE_Q40, n)
             + (96'd1 << (CALC_FRAC - COEF_FRAC - 1))) >> (CALC_FRAC - COEF_FRAC);
        return v[COEF_W-1:0];
    endfunction

endpackage

// File: rtl/logatt_sync.sv
module logatt_sync #(
    parameter int               W       = 1,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/logatt_write_ctrl.sv
module logatt_write_ctrl
    import logatt_pkg::*;
#(
    parameter load_mode_e LOAD_MODE      = LOAD_EDGE,
    parameter int         REFRESH_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_sample_t       synced,
    output logic [CODE_W-1:0] code,
    output logic              busy
);

    localparam int CNT_W = (REFRESH_CYCLES < 1) ? 1 : $clog2(REFRESH_CYCLES + 1);

    logic [CODE_W-1:0] code_q;

    if (LOAD_MODE == LOAD_EDGE) begin : g_edge
        bus_sample_t      prev_q;
        logic [CNT_W-1:0] cnt_q;
        logic             busy_q;
        logic             wr_rise;
        logic             take;

        assign busy_q  = (cnt_q != '0);
        assign wr_rise = synced.wr_n & ~prev_q.wr_n;
        assign take    = wr_rise & ~prev_q.cs_n & ~busy_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= BUS_IDLE;
                code_q <= '0;
                cnt_q  <= '0;
            end else begin
                prev_q <= synced;
                if (take) begin
                    code_q <= prev_q.data;
                    cnt_q  <= CNT_W'(REFRESH_CYCLES);
                end else if (busy_q) begin
                    cnt_q  <= cnt_q - 1'b1;
                end
            end
        end

        assign busy = busy_q;

        if (REFRESH_CYCLES > 0) begin : g_chk_busy
            assert_busy_after_load_R7: assert property (@(posedge clk) disable iff (rst)
                take |=> busy_q)
                else $error("busy not raised after a load");
        end

        assert_ignore_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
            (busy_q && synced.wr_n && !prev_q.wr_n) |=> (code_q == $past(code_q)))
            else $error("write accepted during refresh holdoff");

    end else begin : g_level
        always_ff @(posedge clk) begin
            if (rst) begin
                code_q <= '0;
            end else if (!synced.cs_n && !synced.wr_n) begin
                code_q <= synced.data;
            end
        end

        assign busy = 1'b0;

        assert_level_hold_R8: assert property (@(posedge clk) disable iff (rst)
            synced.wr_n |=> (code_q == $past(code_q)))
            else $error("transparent latch moved with strobe high");
    end

    assign code = code_q;

endmodule

// File: rtl/logatt_gain_decode.sv
module logatt_gain_decode
    import logatt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    output logic [GAIN_W-1:0] gain
);

    localparam int PROD_W = GAIN_W + COEF_W;
    localparam logic [PROD_W-1:0] ROUND_HALF = PROD_W'(1) << (COEF_FRAC - 1);

    logic [GAIN_W-1:0] fine_rom   [FINE_N];
    logic [COEF_W-1:0] coarse_rom [FINE_N];

    for (genvar f = 0; f < FINE_N; f++) begin : g_fine
        assign fine_rom[f] = fine_entry(f);
    end

    // The row past the last coarse step carries a zero factor: the mute row
    for (genvar r = 0; r < FINE_N; r++) begin : g_coarse
        if (r < COARSE_N) begin : g_step
            assign coarse_rom[r] = coarse_entry(r);
        end else begin : g_mute
            assign coarse_rom[r] = '0;
        end
    end

    code_t             split;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] rounded;
    logic [GAIN_W-1:0] gain_q;

    assign split   = code;
    assign prod    = PROD_W'(fine_rom[split.col]) * PROD_W'(coarse_rom[split.row]);
    assign rounded = (prod + ROUND_HALF) >> COEF_FRAC;

    always_ff @(posedge clk) begin
        if (rst) gain_q <= GAIN_FULL;
        else     gain_q <= rounded[GAIN_W-1:0];
    end

    assign gain = gain_q;

    assert_unity_at_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (code == '0) |=> (gain_q == GAIN_FULL))
        else $error("code zero did not give full scale");

    assert_mute_top_row_R3: assert property (@(posedge clk) disable iff (rst)
        (code[CODE_W-1 -: NIB_W] == '1) |=> (gain_q == '0))
        else $error("mute code gave nonzero gain");

    assert_non_increasing_R4: assert property (@(posedge clk) disable iff (rst)
        (code > $past(code)) |=> (gain_q <= $past(gain_q)))
        else $error("gain rose with a larger code");

endmodule

// File: rtl/logatt_decoder.sv
module logatt_decoder
    import logatt_pkg::*;
#(
    parameter load_mode_e LOAD_MODE      = LOAD_EDGE,
    parameter int         REFRESH_CYCLES = 12,
    parameter int         SYNC_STAGES    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CODE_W-1:0]  bus_data,
    input  logic               cs_n,
    input  logic               wr_n,
    output logic [GAIN_W-1:0]  gain_word,
    output logic               busy
);

    localparam int SAMPLE_W = $bits(bus_sample_t);

    bus_sample_t       raw;
    bus_sample_t       synced;
    logic [CODE_W-1:0] code;

    assign raw = '{cs_n: cs_n, wr_n: wr_n, data: bus_data};

    logatt_sync #(
        .W       (SAMPLE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    logatt_write_ctrl #(
        .LOAD_MODE      (LOAD_MODE),
        .REFRESH_CYCLES (REFRESH_CYCLES)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .synced (synced),
        .code   (code),
        .busy   (busy)
    );

    logatt_gain_decode u_decode (
        .clk  (clk),
        .rst  (rst),
        .code (code),
        .gain (gain_word)
    );

endmodule

// File: tb/tb_logatt_decoder.sv
module tb_logatt_decoder;
    import logatt_pkg::*;

    localparam int REFRESH = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  data = 8'h00;
    logic        cs_e = 1'b1, wr_e = 1'b1;
    logic        cs_l = 1'b1, wr_l = 1'b1;
    logic [16:0] gain_e, gain_l;
    logic        busy_e, busy_l;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    logatt_decoder #(.LOAD_MODE(LOAD_EDGE), .REFRESH_CYCLES(REFRESH)) dut (
        .clk(clk), .rst(rst), .bus_data(data), .cs_n(cs_e), .wr_n(wr_e),
        .gain_word(gain_e), .busy(busy_e));

    logatt_decoder #(.LOAD_MODE(LOAD_LEVEL), .REFRESH_CYCLES(REFRESH)) dut_lvl (
        .clk(clk), .rst(rst), .bus_data(data), .cs_n(cs_l), .wr_n(wr_l),
        .gain_word(gain_l), .busy(busy_l));

    function automatic int ideal(input int n);
        real r;
        if (n >= 240) return 0;
        r = 131071.0 * $pow(10.0, -0.375 * n / 20.0);
        return $rtoi(r + 0.5);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_gain(input string req, input int act, input int code);
        int e;
        e = ideal(code);
        check((act - e <= 1) && (e - act <= 1), req, act, e);
    endtask

    task automatic edge_write(input logic [7:0] v);
        @(negedge clk); data = v; cs_e = 1'b0; wr_e = 1'b0;
        repeat (2) @(negedge clk);
        wr_e = 1'b1;
        @(negedge clk); cs_e = 1'b1;
    endtask

    task automatic settle();
        repeat (REFRESH + 6) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int prev;
        int hi;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(gain_e == 17'h1FFFF, "R1 reset gain edge", gain_e, 17'h1FFFF);
        check(busy_e == 1'b0, "R1 reset busy", busy_e, 0);
        check(gain_l == 17'h1FFFF, "R1 reset gain level", gain_l, 17'h1FFFF);

        // R2/R3/R4/R1: ascending sweep over every code
        prev = 17'h1FFFF;
        for (int n = 0; n < 256; n++) begin
            edge_write(8'(n));
            settle();
            if (n == 0) check(gain_e == 17'h1FFFF, "R1 code zero", gain_e, 17'h1FFFF);
            if (n >= 240) check(gain_e == 0, "R3 mute code", gain_e, 0);
            else          check_gain("R2 sweep value", gain_e, n);
            check(int'(gain_e) <= prev, "R4 non-increasing", gain_e, prev);
            prev = gain_e;
        end

        // R5: latency and pre-edge capture
        @(negedge clk); data = 8'h2A; cs_e = 1'b0; wr_e = 1'b0;
        repeat (2) @(negedge clk);
        wr_e = 1'b1; data = 8'h77;
        repeat (4) @(posedge clk);
        @(negedge clk);
        cs_e = 1'b1;
        check_gain("R5 pre-edge byte after four edges", gain_e, 8'h2A);
        settle();

        // R7: busy length
        @(negedge clk); data = 8'h21; cs_e = 1'b0; wr_e = 1'b0;
        repeat (2) @(negedge clk);
        wr_e = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cs_e = 1'b1;
        check(busy_e == 1'b1, "R7 busy raised", busy_e, 1);
        hi = 0;
        while (busy_e && hi < 100) begin
            hi++;
            @(negedge clk);
        end
        check(hi == REFRESH, "R7 busy length", hi, REFRESH);
        settle();

        // R7: write during holdoff ignored
        edge_write(8'h10);
        edge_write(8'h50);
        settle();
        check_gain("R7 second write ignored", gain_e, 8'h10);
        edge_write(8'h50);
        settle();
        check_gain("R7 write after holdoff", gain_e, 8'h50);

        // R6: strobe with chip select high
        @(negedge clk); data = 8'h80; wr_e = 1'b0;
        repeat (2) @(negedge clk);
        wr_e = 1'b1;
        settle();
        check_gain("R6 deselected strobe", gain_e, 8'h50);

        // R6: data moves while strobe held low
        @(negedge clk); data = 8'h03; cs_e = 1'b0; wr_e = 1'b0;
        repeat (3) @(negedge clk);
        data = 8'h64;
        repeat (6) @(negedge clk);
        check_gain("R6 no edge no load", gain_e, 8'h50);
        wr_e = 1'b1;
        @(negedge clk); cs_e = 1'b1;
        settle();
        check_gain("R5 last byte before edge", gain_e, 8'h64);

        // R8: transparent latch
        @(negedge clk); cs_l = 1'b0; wr_l = 1'b0; data = 8'h05;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_gain("R8 follows bus", gain_l, 8'h05);
        check(busy_l == 1'b0, "R8 busy idle", busy_l, 0);
        data = 8'h33;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_gain("R8 follows second value", gain_l, 8'h33);
        data = 8'h99; wr_l = 1'b1;
        repeat (8) @(negedge clk);
        check_gain("R8 holds when strobe high", gain_l, 8'h33);
        wr_l = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_gain("R8 reopened", gain_l, 8'h99);
        data = 8'hF4;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(gain_l == 0, "R3 mute in level mode", gain_l, 0);
        wr_l = 1'b1; cs_l = 1'b1;
        check_gain("R6 edge unit unaffected", gain_e, 8'h64);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule